// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is a target on a two-wire I2C bus. It gives a controller access to a bank of byte-wide registers through one 8-bit register pointer that advances by itself. The open-drain lines are sampled into the system clock domain through two-flop synchronizers. All detection of START, repeated START, STOP and SCL edges works on these synchronized copies. The target answers a single 7-bit address set by a parameter. It never stretches the clock.

In a write transfer, the first data byte after any bus condition loads the pointer. Each later byte is stored at the pointer, and the pointer then steps by one. In a read transfer, the byte at the pointer is shifted out MSB first, and the pointer then steps by one. The pointer is not cleared by START, repeated START or STOP. The usual sequence is therefore a write that sets the pointer, then a repeated START and a read. A build-time parameter chooses one of two sets of reset contents.

The link engine moves through these states:
- S_IDLE: not selected.
- S_ADDR: shifting in the address byte.
- S_ADDR_ACK: acknowledging the address.
- S_WR_BITS: shifting in a write byte.
- S_WR_ACK: acknowledging a write byte.
- S_RD_BITS: shifting out a read byte.
- S_RD_ACK: sampling the controller's acknowledge.

Its transitions are:
- START from any state goes to S_ADDR. STOP from any state goes to S_IDLE.
- From S_ADDR, an address match goes to S_ADDR_ACK and a mismatch goes to S_IDLE.
- From S_ADDR_ACK, a write goes to S_WR_BITS and a read goes to S_RD_BITS.
- S_WR_BITS goes to S_WR_ACK after eight bits, and S_WR_ACK returns to S_WR_BITS.
- S_RD_BITS goes to S_RD_ACK after eight bits.
- From S_RD_ACK, an ACK returns to S_RD_BITS and a NACK goes to S_IDLE.

Top module: `i2c_regbank_target`

## Requirements
- R1: A START followed by an address byte whose upper seven bits equal TGT_ADDR is acknowledged: SDA is pulled low through the ninth SCL clock. For any other address, SDA stays released until the next START.
- R2: Every data byte written to the selected target is acknowledged by pulling SDA low during the ninth clock.
- R3: The first data byte written after a START, repeated START or STOP loads the pointer and is stored in no register.
- R4: Each further written byte is stored in the register the pointer selects, and the pointer then increments by one.
- R5: A read returns the register at the pointer and increments the pointer. When the pointer is 0xFF, the read returns 0xFF and the pointer keeps the value 0xFF.
- R6: The pointer keeps its value across START, repeated START and STOP. A pointer-setting write followed by a read transfer therefore reads from the chosen register.
- R7: A data byte written while the pointer is 0xFF is discarded, and the pointer wraps to 0x00.
- R8: Read data leaves MSB first, and SDA changes only while SCL is low. After the controller NACKs a read byte, SDA stays released until the next START.
- R9: Reset clears every register, the pointer and the byte phase, then loads the variant defaults. Variant A (DEFAULTS = DEFSET_A, value 0) holds 0x01 at 0x03 and 0x16 at 0x23. Variant B (DEFSET_B, value 1) holds 0xC2 at 0x00 and 0x06 at 0x03.
- R10: Bit 0 of the address byte selects the direction: 0 is a write, 1 is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| sda_pull_low | output | 1 | When 1, the open-drain SDA driver pulls the line low |

## Verification
Two things happen on the same write strobe: storing a data byte and advancing the pointer. At the end of the bank the store must be dropped while the advance still wraps. The bench provokes this with one write transfer that starts at 0xFE and carries three data bytes. It judges the result by reading back 0xFE, 0xFF and 0x00 and comparing them with a behavioural model of the bank. The same model predicts the SDA level the target should drive in every bit window, and the bench compares that level on every clock. A shift in ACK timing or read data therefore shows up in the cycle where it happens.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        DEFSET_A = 1'b0,
        DEFSET_B = 1'b1
    } defset_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_BITS,
        S_WR_ACK,
        S_RD_BITS,
        S_RD_ACK
    } link_state_e;

    // synchronized line levels plus one-cycle condition pulses
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [BYTE_W-1:0] reset_value(defset_e set, int unsigned idx);
        reset_value = '0;
        if (set == DEFSET_A) begin
            if (idx == 32'h03)      reset_value = 8'h01;
            else if (idx == 32'h23) reset_value = 8'h16;
        end else begin
            if (idx == 32'h00)      reset_value = 8'hC2;
            else if (idx == 32'h03) reset_value = 8'h06;
        end
    endfunction

endpackage

// File: rtl/i2ct_sync.sv
`timescale 1ns/1ps
module i2ct_sync #(
    parameter int              WIDTH  = 2,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= INIT;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= INIT;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/i2ct_cond.sv
`timescale 1ns/1ps
module i2ct_cond
    import i2ct_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);

    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2ct_link.sv
`timescale 1ns/1ps
module i2ct_link
    import i2ct_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              bus_evt,
    output logic              sda_low
);

    localparam int          CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    link_state_e       st, st_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [BYTE_W-1:0] sh, sh_nx;
    logic              rw, rw_nx;
    logic              mack, mack_nx;
    logic              low_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            cnt     <= '0;
            sh      <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            st      <= st_nx;
            cnt     <= cnt_nx;
            sh      <= sh_nx;
            rw      <= rw_nx;
            mack    <= mack_nx;
            sda_low <= low_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        cnt_nx  = cnt;
        sh_nx   = sh;
        rw_nx   = rw;
        mack_nx = mack;
        low_nx  = sda_low;
        rd_stb  = 1'b0;
        wr_stb  = 1'b0;
        if (ev.stop) begin
            st_nx  = S_IDLE;
            low_nx = 1'b0;
        end else if (ev.start) begin
            st_nx  = S_ADDR;
            cnt_nx = '0;
            low_nx = 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    low_nx = 1'b0;
                end
                S_ADDR: begin
                    if (ev.scl_rise && cnt < FULL) begin
                        sh_nx  = {sh[BYTE_W-2:0], ev.sda};
                        cnt_nx = cnt + 1'b1;
                    end else if (ev.scl_fall && cnt == FULL) begin
                        if (sh[BYTE_W-1:1] == TGT_ADDR) begin
                            st_nx  = S_ADDR_ACK;
                            rw_nx  = sh[0];
                            low_nx = 1'b1;
                        end else begin
                            st_nx = S_IDLE;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        cnt_nx = '0;
                        if (rw) begin
                            st_nx  = S_RD_BITS;
                            rd_stb = 1'b1;
                            sh_nx  = rd_byte;
                            low_nx = ~rd_byte[BYTE_W-1];
                        end else begin
                            st_nx  = S_WR_BITS;
                            low_nx = 1'b0;
                        end
                    end
                end
                S_WR_BITS: begin
                    if (ev.scl_rise && cnt < FULL) begin
                        sh_nx  = {sh[BYTE_W-2:0], ev.sda};
                        cnt_nx = cnt + 1'b1;
                    end else if (ev.scl_fall && cnt == FULL) begin
                        wr_stb = 1'b1;
                        st_nx  = S_WR_ACK;
                        low_nx = 1'b1;
                    end
                end
                S_WR_ACK: begin
                    if (ev.scl_fall) begin
                        st_nx  = S_WR_BITS;
                        cnt_nx = '0;
                        low_nx = 1'b0;
                    end
                end
                S_RD_BITS: begin
                    if (ev.scl_rise && cnt < FULL) begin
                        cnt_nx = cnt + 1'b1;
                    end else if (ev.scl_fall) begin
                        if (cnt == FULL) begin
                            st_nx  = S_RD_ACK;
                            low_nx = 1'b0;
                        end else begin
                            sh_nx  = {sh[BYTE_W-2:0], 1'b0};
                            low_nx = ~sh[BYTE_W-2];
                        end
                    end
                end
                S_RD_ACK: begin
                    if (ev.scl_rise) begin
                        mack_nx = ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack) begin
                            st_nx  = S_RD_BITS;
                            rd_stb = 1'b1;
                            sh_nx  = rd_byte;
                            cnt_nx = '0;
                            low_nx = ~rd_byte[BYTE_W-1];
                        end else begin
                            st_nx  = S_IDLE;
                            low_nx = 1'b0;
                        end
                    end
                end
                default: begin
                    st_nx  = S_IDLE;
                    low_nx = 1'b0;
                end
            endcase
        end
    end

    assign wr_byte = sh;
    assign bus_evt = ev.start | ev.stop;

    // R8
    sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> !ev.scl);

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !sda_low);

    // R2
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WR_ACK) |-> sda_low);

    // R8
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RD_ACK && ev.scl_fall && !mack && !ev.start && !ev.stop)
        |=> (st == S_IDLE && !sda_low));

    // R10
    dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADDR_ACK && ev.scl_fall && rw && !ev.start && !ev.stop)
        |=> (st == S_RD_BITS));

endmodule

// File: rtl/i2ct_bank.sv
`timescale 1ns/1ps
module i2ct_bank
    import i2ct_pkg::*;
#(
    parameter int      NREGS    = 255,
    parameter defset_e DEFAULTS = DEFSET_A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_evt,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_byte
);

    localparam logic [BYTE_W-1:0] LIMIT = BYTE_W'(NREGS);

    logic [BYTE_W-1:0] ptr;
    logic              phase;
    logic              in_range;
    logic              store_en;
    logic [BYTE_W-1:0] regs [NREGS];

    assign in_range = (ptr < LIMIT);
    assign store_en = wr_stb & phase & ~bus_evt & in_range;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] RV = reset_value(DEFAULTS, g);
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= RV;
            else if (store_en && ptr == BYTE_W'(g))    q <= wr_byte;
        end
        assign regs[g] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr   <= '0;
            phase <= 1'b0;
        end else if (bus_evt) begin
            phase <= 1'b0;
        end else if (wr_stb) begin
            if (!phase) begin
                ptr   <= wr_byte;
                phase <= 1'b1;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end else if (rd_stb && in_range) begin
            ptr <= ptr + 1'b1;
        end
    end

    assign rd_byte = in_range ? regs[ptr] : '1;

    // R3
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !phase && !bus_evt) |=> (ptr == $past(wr_byte) && phase));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && phase && !bus_evt) |=> (ptr == $past(ptr) + 1'b1));

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && phase && !bus_evt && ptr == '1) |=> (ptr == '0));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && !bus_evt && ptr == '1) |=> (ptr == '1));

    // R6
    evt_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_evt |=> $stable(ptr));

endmodule

// File: rtl/i2c_regbank_target.sv
`timescale 1ns/1ps
module i2c_regbank_target
    import i2ct_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'h34,
    parameter defset_e    DEFAULTS    = DEFSET_A,
    parameter int         NREGS       = 255,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull_low
);

    logic              scl_s, sda_s;
    bus_ev_t           ev;
    logic              rd_stb, wr_stb, bus_evt;
    logic [BYTE_W-1:0] wr_byte, rd_byte;

    i2ct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    i2ct_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .ev    (ev)
    );

    i2ct_link #(.TGT_ADDR(TGT_ADDR)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .rd_byte (rd_byte),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .bus_evt (bus_evt),
        .sda_low (sda_pull_low)
    );

    i2ct_bank #(.NREGS(NREGS), .DEFAULTS(DEFAULTS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_evt (bus_evt),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .rd_stb  (rd_stb),
        .rd_byte (rd_byte)
    );

endmodule

// File: tb/i2c_regbank_target_tb.sv
`timescale 1ns/1ps
module i2c_regbank_target_tb;
    import i2ct_pkg::*;

    localparam logic [6:0] ADDR_A = 7'h34;
    localparam logic [6:0] ADDR_B = 7'h35;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_ctrl = 1'b1;
    logic low_a, low_b;
    wire  bus_low = low_a | low_b;
    wire  sda_bus = sda_ctrl & ~bus_low;

    i2c_regbank_target #(.TGT_ADDR(ADDR_A), .DEFAULTS(DEFSET_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_pull_low(low_a));

    i2c_regbank_target #(.TGT_ADDR(ADDR_B), .DEFAULTS(DEFSET_B)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_pull_low(low_b));

    int n_run = 0;
    int n_fail = 0;

    // behavioural model of both banks
    logic [7:0] mem [2][255];
    int         ptr_m [2];
    bit         ph_m [2];
    logic [7:0] wq [$];

    // per-clock comparison of the driven SDA level
    int   exp_low = -1;
    bit   win_err = 1'b0;
    logic win_act = 1'b0;

    always @(negedge clk) begin
        #1;
        if (exp_low >= 0 && bus_low !== exp_low[0]) begin
            win_err = 1'b1;
            win_act = bus_low;
        end
    end

    task automatic check(bit ok, string tag, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    function automatic int dev_of(logic [6:0] a);
        if (a == ADDR_A) return 0;
        if (a == ADDR_B) return 1;
        return -1;
    endfunction

    task automatic model_wr(int d, logic [7:0] b);
        if (!ph_m[d]) begin
            ptr_m[d] = b;
            ph_m[d]  = 1'b1;
        end else begin
            if (ptr_m[d] < 255) mem[d][ptr_m[d]] = b;
            ptr_m[d] = (ptr_m[d] + 1) & 255;
        end
    endtask

    task automatic model_rd(int d, output logic [7:0] v);
        if (ptr_m[d] < 255) begin
            v = mem[d][ptr_m[d]];
            ptr_m[d]++;
        end else begin
            v = 8'hFF;
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(logic drv, int expl, string tag, output logic smp);
        sda_ctrl = drv;
        exp_low  = expl;
        win_err  = 1'b0;
        wait_clk(Q);
        scl = 1'b1;
        wait_clk(Q);
        smp = sda_bus;
        wait_clk(Q);
        scl = 1'b0;
        exp_low = -1;
        check(!win_err, tag, win_act, expl);
        wait_clk(Q);
    endtask

    task automatic bus_start();
        sda_ctrl = 1'b1;
        exp_low  = 0;
        win_err  = 1'b0;
        wait_clk(Q);
        scl = 1'b1;
        wait_clk(Q);
        sda_ctrl = 1'b0;
        wait_clk(Q);
        scl = 1'b0;
        exp_low = -1;
        check(!win_err, "R1 start", win_act, 0);
        wait_clk(Q);
        ph_m[0] = 1'b0;
        ph_m[1] = 1'b0;
    endtask

    task automatic bus_stop();
        sda_ctrl = 1'b0;
        exp_low  = 0;
        win_err  = 1'b0;
        wait_clk(Q);
        scl = 1'b1;
        wait_clk(Q);
        sda_ctrl = 1'b1;
        wait_clk(Q);
        exp_low = -1;
        check(!win_err, "R8 stop", win_act, 0);
        ph_m[0] = 1'b0;
        ph_m[1] = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b, bit acks, string tag);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], 0, tag, s);
        bit_cycle(1'b1, acks ? 1 : 0, tag, s);
        check(s == !acks, tag, s, !acks);
    endtask

    task automatic recv_byte(logic [7:0] e, bit m_ack, string tag);
        logic s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, e[i] ? 0 : 1, "R8", s);
            got[i] = s;
        end
        check(got == e, tag, got, e);
        bit_cycle(m_ack ? 1'b0 : 1'b1, 0, "R8", s);
    endtask

    task automatic do_write(logic [6:0] a, bit end_stop, string tag);
        int d;
        d = dev_of(a);
        bus_start();
        send_byte({a, 1'b0}, d >= 0, "R1");
        foreach (wq[i]) begin
            send_byte(wq[i], d >= 0, tag);
            if (d >= 0) model_wr(d, wq[i]);
        end
        if (end_stop) bus_stop();
    endtask

    task automatic do_read(logic [6:0] a, int n, string tag);
        int d;
        logic [7:0] e;
        d = dev_of(a);
        bus_start();
        send_byte({a, 1'b1}, 1'b1, "R10");
        for (int k = 0; k < n; k++) begin
            model_rd(d, e);
            recv_byte(e, k != n - 1, tag);
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic s;
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < 255; i++) mem[d][i] = 8'h00;
            ptr_m[d] = 0;
            ph_m[d]  = 1'b0;
        end
        mem[0][8'h03] = 8'h01;
        mem[0][8'h23] = 8'h16;
        mem[1][8'h00] = 8'hC2;
        mem[1][8'h03] = 8'h06;

        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(10);
        // R9: lines released after reset
        check(bus_low == 1'b0, "R9 idle", bus_low, 0);

        // R9: pointer starts at zero in both variants
        do_read(ADDR_A, 1, "R9");
        do_read(ADDR_B, 2, "R9");

        // R6: pointer set, repeated START, read
        wq = {8'h22};
        do_write(ADDR_A, 1'b0, "R2");
        do_read(ADDR_A, 3, "R6");

        // R4: sequential store, pointer kept across STOP
        wq = {8'h10, 8'hA5, 8'h5A, 8'h3C};
        do_write(ADDR_A, 1'b1, "R4");
        wq = {8'h10};
        do_write(ADDR_A, 1'b1, "R3");
        do_read(ADDR_A, 3, "R4");

        // R7 and R5: end of bank, discard and wrap, read stall at 0xFF
        wq = {8'hFE, 8'h11, 8'h22, 8'h33};
        do_write(ADDR_A, 1'b1, "R7");
        wq = {8'hFE};
        do_write(ADDR_A, 1'b1, "R3");
        do_read(ADDR_A, 3, "R5");
        wq = {8'h00};
        do_write(ADDR_A, 1'b1, "R7");
        do_read(ADDR_A, 1, "R7");

        // R1: foreign address ignored
        wq = {8'h03, 8'h77};
        do_write(7'h50, 1'b1, "R1");
        wq = {8'h03};
        do_write(ADDR_A, 1'b0, "R1");
        do_read(ADDR_A, 1, "R1");

        // R3: pointer byte is never stored
        wq = {8'h40, 8'h99};
        do_write(ADDR_A, 1'b1, "R2");
        wq = {8'h40};
        do_write(ADDR_A, 1'b1, "R3");
        do_read(ADDR_A, 2, "R3");

        // R9: variant B identity through write then read
        wq = {8'h03};
        do_write(ADDR_B, 1'b0, "R2");
        do_read(ADDR_B, 1, "R9");

        // R8: after NACK the target stays off the line
        wq = {8'h23};
        do_write(ADDR_A, 1'b0, "R2");
        bus_start();
        send_byte({ADDR_A, 1'b1}, 1'b1, "R10");
        begin
            logic [7:0] e;
            model_rd(0, e);
            recv_byte(e, 1'b0, "R8");
        end
        for (int i = 0; i < 9; i++) bit_cycle(1'b1, 0, "R8", s);
        bus_stop();
        do_read(ADDR_A, 1, "R6");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule